// File: doc/BRIEF.md
# Configuration-Phase Clock and Reset Controller

This block holds a small control word and applies it to the chip's clocks, reset and I/O while a configuration download is running. Each of the global clock inputs and fast clock inputs has its own mask bit. When that bit is set and the download-active input is high, the clock is stopped. The stop takes effect on that clock's own rising edge, and the stopped clock rests at logic high. A clock whose mask bit is clear always passes through.

The same word sets three more things. It can hold the core flops in an active-low global reset from the start of a download until the download-done strobe rises. It can let a dedicated pin force all user I/O into tristate. It can grant access to the internal scan chains, and that grant always yields to an external lockout input. One more bit keeps the configuration clock running after the download. That bit is stored and read back only, because its consumer lies outside this block.

The loader that drives the download signals and the scan chains themselves sit outside the block. Software writes the word through a single-cycle write port and sees it again on a read-back bus.

Top module: `cfg_phase_clkrst_ctrl`

## Requirements
- R1: The control word resets to zero and reads back on `rd_data` one cycle after a write. Bits 7:0 mask the global clocks and bits 9:8 mask the fast clocks. Bit 10 enables the reset hold, bit 11 enables the tristate pin, bit 12 is the debug enable, bit 13 is the JTAG enable and bit 14 keeps the configuration clock running. Bits 31:15 are reserved: they always read 0 and writes to them have no effect.
- R2: When a clock's mask bit is 1 and `cfg_active` is high, that clock's output stops within three of its own rising edges and then stays at logic 1.
- R3: A clock whose mask bit is 0 follows its input whatever `cfg_active` does. This holds even while other clocks are stopped.
- R4: A gated clock opens and closes only on its source's rising edge. No output high phase is shorter than the source's high phase, no output low phase is shorter than the source's low phase, and an output falls only together with its source.
- R5: With bit 10 set, a rise of `cfg_active` drives `gsr_n` low. It stays low, even after `cfg_active` falls, until a rising edge of `cfg_done` releases it. A release that happens while the download is still active is not undone until `cfg_active` rises again.
- R6: With bit 10 clear, `gsr_n` stays high through a whole download.
- R7: `io_tri_en` is high exactly when bit 11 is set and `ots_pin` is high.
- R8: `scan_en` is high exactly when bits 12 and 13 are both set and `cfg_lockout` is low.
- R9: Bit 14 is stored and read back like the other defined bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and reset-logic clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word write data |
| rd_data | output | 32 | Control word read-back |
| gclk_in | input | 8 | Raw global clocks |
| gclk_out | output | 8 | Gated global clocks |
| fclk_in | input | 2 | Raw fast clocks |
| fclk_out | output | 2 | Gated fast clocks |
| cfg_active | input | 1 | High while a configuration download runs |
| cfg_done | input | 1 | Download-complete strobe; its rising edge releases reset |
| ots_pin | input | 1 | Global tristate request pin |
| cfg_lockout | input | 1 | Configuration memory lockout; blocks scan access |
| gsr_n | output | 1 | Active-low global set/reset to core flops |
| io_tri_en | output | 1 | Tristate all user I/O |
| scan_en | output | 1 | Internal scan-chain access granted |

## Verification
The gating sweep runs with every one-hot mask, with the all-set and all-clear masks, and with the two alternating masks. Each mask runs with the download both idle and active, on ten sources of different periods. This separates a mask bit that reaches the wrong clock, or a gate that ignores the download, from a correct gate. A pulse-width monitor on every output runs through all transitions, so a gate that switches on a falling edge or parks low shows up. The reset hold is driven through a download that ends before its done strobe, a done strobe that arrives during a download, and a download with the hold bit clear. The tristate and scan controls are swept over every combination of their inputs.

// File: rtl/cfgctl_pkg.sv
package cfgctl_pkg;

   // Single-bit controls placed directly above the clock mask bits.
   typedef enum int unsigned {
      FLD_GSR_HOLD  = 0,
      FLD_TRI_PIN   = 1,
      FLD_DBG_EN    = 2,
      FLD_JTAG_EN   = 3,
      FLD_KEEP_RUN  = 4,
      FLD_COUNT     = 5
   } ctl_field_e;

   localparam int unsigned MIN_SYNC_STAGES = 2;

   function automatic int unsigned fld_pos(int unsigned n_clk, ctl_field_e f);
      return n_clk + int'(f);
   endfunction

endpackage

// File: rtl/cfgctl_sync.sv
module cfgctl_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < cfgctl_pkg::MIN_SYNC_STAGES) begin : g_bad_stages
      $error("cfgctl_sync: STAGES below minimum");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/cfgctl_regfile.sv
module cfgctl_regfile #(
   parameter int unsigned REG_W = 32,
   parameter int unsigned DEF_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] ctl_q
);

   if (DEF_W >= REG_W) begin : g_bad_width
      $error("cfgctl_regfile: defined bits must leave reserved space");
   end

   localparam logic [REG_W-1:0] KEEP_MASK = {{(REG_W-DEF_W){1'b0}}, {DEF_W{1'b1}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else if (wr_en) begin
         ctl_q <= wr_data & KEEP_MASK;
      end
   end

endmodule

// File: rtl/cfgctl_clk_gate.sv
module cfgctl_clk_gate #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic gate_req,
   output logic gated_clk
);

   logic req_s;
   logic park_q;

   // Request crosses into the source clock's own domain first.
   cfgctl_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (src_clk),
      .rst_n (rst_n),
      .d     (gate_req),
      .q     (req_s)
   );

   // Updated only at a rising edge, while src_clk is already high,
   // so the OR below can neither shorten nor split a phase.
   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         park_q <= 1'b0;
      end else begin
         park_q <= req_s;
      end
   end

   assign gated_clk = src_clk | park_q;

endmodule

// File: rtl/cfgctl_gsr.sv
module cfgctl_gsr #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold_en,
   input  logic cfg_active,
   input  logic cfg_done,
   output logic gsr_n
);

   logic act_s, act_d;
   logic done_s, done_d;
   logic hold_q;

   cfgctl_sync #(.STAGES(SYNC_STAGES)) u_act_sync (
      .clk (clk), .rst_n (rst_n), .d (cfg_active), .q (act_s)
   );

   cfgctl_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk (clk), .rst_n (rst_n), .d (cfg_done), .q (done_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_d  <= 1'b0;
         done_d <= 1'b0;
         hold_q <= 1'b0;
      end else begin
         act_d  <= act_s;
         done_d <= done_s;
         if (done_s && !done_d) begin
            hold_q <= 1'b0;
         end else if (act_s && !act_d && hold_en) begin
            hold_q <= 1'b1;
         end
      end
   end

   assign gsr_n = ~hold_q;

endmodule

// File: rtl/cfg_phase_clkrst_ctrl.sv
module cfg_phase_clkrst_ctrl #(
   parameter int unsigned GCLK_N      = 8,
   parameter int unsigned FCLK_N      = 2,
   parameter int unsigned REG_W       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic [GCLK_N-1:0] gclk_in,
   output logic [GCLK_N-1:0] gclk_out,
   input  logic [FCLK_N-1:0] fclk_in,
   output logic [FCLK_N-1:0] fclk_out,
   input  logic              cfg_active,
   input  logic              cfg_done,
   input  logic              ots_pin,
   input  logic              cfg_lockout,
   output logic              gsr_n,
   output logic              io_tri_en,
   output logic              scan_en
);
   import cfgctl_pkg::*;

   localparam int unsigned NCLK   = GCLK_N + FCLK_N;
   localparam int unsigned DEF_W  = NCLK + int'(FLD_COUNT);
   localparam int unsigned P_GSR  = fld_pos(NCLK, FLD_GSR_HOLD);
   localparam int unsigned P_TRI  = fld_pos(NCLK, FLD_TRI_PIN);
   localparam int unsigned P_DBG  = fld_pos(NCLK, FLD_DBG_EN);
   localparam int unsigned P_JTAG = fld_pos(NCLK, FLD_JTAG_EN);

   if (GCLK_N < 1 || FCLK_N < 1) begin : g_bad_clocks
      $error("cfg_phase_clkrst_ctrl: need at least one clock of each kind");
   end
   if (REG_W <= DEF_W) begin : g_bad_reg
      $error("cfg_phase_clkrst_ctrl: REG_W too small for the defined fields");
   end

   logic [REG_W-1:0] ctl;
   logic [NCLK-1:0]  src_all;
   logic [NCLK-1:0]  gated_all;

   cfgctl_regfile #(.REG_W(REG_W), .DEF_W(DEF_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .ctl_q   (ctl)
   );

   assign rd_data = ctl;
   assign src_all = {fclk_in, gclk_in};

   for (genvar i = 0; i < NCLK; i++) begin : g_gate
      logic req;
      assign req = ctl[i] & cfg_active;
      cfgctl_clk_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
         .src_clk   (src_all[i]),
         .rst_n     (rst_n),
         .gate_req  (req),
         .gated_clk (gated_all[i])
      );
   end

   assign gclk_out = gated_all[GCLK_N-1:0];
   assign fclk_out = gated_all[NCLK-1:GCLK_N];

   cfgctl_gsr #(.SYNC_STAGES(SYNC_STAGES)) u_gsr (
      .clk        (clk),
      .rst_n      (rst_n),
      .hold_en    (ctl[P_GSR]),
      .cfg_active (cfg_active),
      .cfg_done   (cfg_done),
      .gsr_n      (gsr_n)
   );

   assign io_tri_en = ctl[P_TRI] & ots_pin;
   assign scan_en   = ctl[P_DBG] & ctl[P_JTAG] & ~cfg_lockout;

endmodule

// File: rtl/cfgctl_chk.sv
module cfgctl_chk #(
   parameter int unsigned GCLK_N = 8,
   parameter int unsigned FCLK_N = 2,
   parameter int unsigned REG_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_W-1:0]  wr_data,
   input logic [REG_W-1:0]  rd_data,
   input logic [GCLK_N-1:0] gclk_in,
   input logic [GCLK_N-1:0] gclk_out,
   input logic [FCLK_N-1:0] fclk_in,
   input logic [FCLK_N-1:0] fclk_out,
   input logic              ots_pin,
   input logic              cfg_lockout,
   input logic              gsr_n,
   input logic              io_tri_en,
   input logic              scan_en
);
   import cfgctl_pkg::*;

   localparam int unsigned NCLK   = GCLK_N + FCLK_N;
   localparam int unsigned DEF_W  = NCLK + int'(FLD_COUNT);
   localparam int unsigned P_GSR  = fld_pos(NCLK, FLD_GSR_HOLD);
   localparam int unsigned P_TRI  = fld_pos(NCLK, FLD_TRI_PIN);
   localparam int unsigned P_DBG  = fld_pos(NCLK, FLD_DBG_EN);
   localparam int unsigned P_JTAG = fld_pos(NCLK, FLD_JTAG_EN);
   localparam logic [REG_W-1:0] KEEP = {{(REG_W-DEF_W){1'b0}}, {DEF_W{1'b1}}};

   logic [NCLK-1:0] src_all, dst_all;
   assign src_all = {fclk_in, gclk_in};
   assign dst_all = {fclk_out, gclk_out};

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~KEEP) == '0);  // R1
   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rd_data == ($past(wr_data) & KEEP));  // R1
   AST_GSR_NEEDS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(gsr_n) |-> $past(rd_data[P_GSR]));  // R6
   AST_TRI_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      io_tri_en |-> (ots_pin && rd_data[P_TRI]));  // R7
   AST_TRI_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[P_TRI] && ots_pin) |-> io_tri_en);  // R7
   AST_SCAN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      scan_en |-> (!cfg_lockout && rd_data[P_DBG] && rd_data[P_JTAG]));  // R8
   AST_SCAN_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[P_DBG] && rd_data[P_JTAG] && !cfg_lockout) |-> scan_en);  // R8

   for (genvar i = 0; i < NCLK; i++) begin : g_fall
      always @(negedge dst_all[i]) begin
         if (rst_n) begin
            AST_FALL_WITH_SRC: assert (src_all[i] == 1'b0);  // R4
         end
      end
   end

endmodule

bind cfg_phase_clkrst_ctrl cfgctl_chk #(
   .GCLK_N (GCLK_N),
   .FCLK_N (FCLK_N),
   .REG_W  (REG_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_data     (wr_data),
   .rd_data     (rd_data),
   .gclk_in     (gclk_in),
   .gclk_out    (gclk_out),
   .fclk_in     (fclk_in),
   .fclk_out    (fclk_out),
   .ots_pin     (ots_pin),
   .cfg_lockout (cfg_lockout),
   .gsr_n       (gsr_n),
   .io_tri_en   (io_tri_en),
   .scan_en     (scan_en)
);

// File: tb/cfg_phase_clkrst_ctrl_tb.sv
`timescale 1ns/1ps
module cfg_phase_clkrst_ctrl_tb;

   localparam int unsigned NCLK  = 10;
   localparam int unsigned DEF_W = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [7:0]  gclk_out;
   logic [1:0]  fclk_out;
   logic        cfg_active = 1'b0;
   logic        cfg_done = 1'b0;
   logic        ots_pin = 1'b0;
   logic        cfg_lockout = 1'b0;
   logic        gsr_n, io_tri_en, scan_en;
   logic [NCLK-1:0] src, outs;

   int unsigned n_checks = 0;
   int unsigned n_errors = 0;
   bit          mon_on = 1'b0;
   int unsigned n_edge [NCLK];
   int unsigned n_runt [NCLK];

   always #5 clk = ~clk;

   cfg_phase_clkrst_ctrl u_dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
      .rd_data (rd_data), .gclk_in (src[7:0]), .gclk_out (gclk_out),
      .fclk_in (src[9:8]), .fclk_out (fclk_out), .cfg_active (cfg_active),
      .cfg_done (cfg_done), .ots_pin (ots_pin), .cfg_lockout (cfg_lockout),
      .gsr_n (gsr_n), .io_tri_en (io_tri_en), .scan_en (scan_en)
   );

   assign outs = {fclk_out, gclk_out};

   // Source i has a half period of 3+i ns; a monitor measures every phase.
   for (genvar i = 0; i < NCLK; i++) begin : g_src
      localparam realtime HALF = 3.0 + i;
      logic    s = 1'b0;
      realtime t_r, t_f;
      bit      seen_r = 1'b0, seen_f = 1'b0;
      assign src[i] = s;
      initial forever #(HALF) s = ~s;
      initial begin n_edge[i] = 0; n_runt[i] = 0; end
      always @(posedge outs[i]) begin
         n_edge[i] = n_edge[i] + 1;
         if (mon_on && seen_f && ($realtime - t_f) < HALF - 0.001) n_runt[i] = n_runt[i] + 1;
         t_r = $realtime; seen_r = mon_on;
      end
      always @(negedge outs[i]) begin
         if (mon_on && seen_r && ($realtime - t_r) < HALF - 0.001) n_runt[i] = n_runt[i] + 1;
         t_f = $realtime; seen_f = mon_on;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic write_ctl(input logic [31:0] v);
      @(negedge clk); wr_en = 1'b1; wr_data = v;
      @(negedge clk); wr_en = 1'b0;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sweep(input logic [NCLK-1:0] mask);
      int unsigned e0 [NCLK];
      logic [NCLK-1:0] lvl;
      write_ctl({22'd0, mask});
      for (int act = 0; act < 2; act++) begin
         cfg_active = act[0];
         #150;
         for (int i = 0; i < NCLK; i++) e0[i] = n_edge[i];
         #100; lvl = outs; #100;
         for (int i = 0; i < NCLK; i++) begin
            int unsigned d;
            d = n_edge[i] - e0[i];
            if (act == 1 && mask[i]) begin
               // R2: stopped clock, no edges, parked high
               check(d == 0 && lvl[i] == 1'b1, "R2", $sformatf("clk%0d mask %0h parked", i, mask),
                     d, 0);
            end else begin
               // R3: unmasked or idle clock keeps running
               check(d > 0, "R3", $sformatf("clk%0d mask %0h act %0d runs", i, mask, act), d, 1);
            end
         end
      end
      cfg_active = 1'b0;
      #150;
   endtask

   initial begin
      #500us;
      n_checks++; n_errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

   initial begin
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(2);
      mon_on = 1'b1;

      // R1 reset state
      check(rd_data == 32'd0, "R1", "reset readback", rd_data, 0);
      check(gsr_n == 1'b1 && io_tri_en == 1'b0 && scan_en == 1'b0, "R1", "reset outputs",
            {gsr_n, io_tri_en, scan_en}, 3'b100);
      check(outs == src, "R3", "reset clocks pass", outs, src);

      // R1 masking of reserved bits
      write_ctl(32'hFFFF_FFFF);
      check(rd_data == 32'h0000_7FFF, "R1", "all-ones write", rd_data, 32'h7FFF);
      write_ctl(32'hFFFF_8000);
      check(rd_data == 32'd0, "R1", "reserved-only write", rd_data, 0);
      write_ctl(32'h1234_5A5A);
      check(rd_data == (32'h1234_5A5A & ((32'd1 << DEF_W) - 1)), "R1", "mixed write",
            rd_data, 32'h1234_5A5A & ((32'd1 << DEF_W) - 1));

      // R9 keep-run bit
      write_ctl(32'h0000_4000);
      check(rd_data == 32'h0000_4000, "R9", "keep-run readback", rd_data, 32'h4000);

      // R2 / R3 gating sweep
      for (int k = 0; k < NCLK; k++) sweep(10'(1 << k));
      sweep(10'h3FF);
      sweep(10'h155);
      sweep(10'h2AA);
      sweep(10'h000);

      // R5 hold, download ends before done
      write_ctl(32'h0000_0400);
      cfg_active = 1'b1; wait_clk(6);
      check(gsr_n == 1'b0, "R5", "reset held in download", gsr_n, 0);
      cfg_active = 1'b0; wait_clk(6);
      check(gsr_n == 1'b0, "R5", "held after active falls", gsr_n, 0);
      cfg_done = 1'b1; wait_clk(4); cfg_done = 1'b0; wait_clk(2);
      check(gsr_n == 1'b1, "R5", "released by done", gsr_n, 1);

      // R5 done during download, no re-assert until next rise
      cfg_active = 1'b1; wait_clk(6);
      check(gsr_n == 1'b0, "R5", "second download held", gsr_n, 0);
      cfg_done = 1'b1; wait_clk(4); cfg_done = 1'b0; wait_clk(6);
      check(gsr_n == 1'b1, "R5", "released while active", gsr_n, 1);
      cfg_active = 1'b0; wait_clk(6);
      check(gsr_n == 1'b1, "R5", "stays released", gsr_n, 1);

      // R6 hold bit clear
      write_ctl(32'h0000_0000);
      cfg_active = 1'b1; wait_clk(8);
      check(gsr_n == 1'b1, "R6", "no hold without bit", gsr_n, 1);
      cfg_done = 1'b1; wait_clk(4); cfg_done = 1'b0;
      cfg_active = 1'b0; wait_clk(6);
      check(gsr_n == 1'b1, "R6", "no hold after download", gsr_n, 1);

      // R7 tristate truth table
      for (int c = 0; c < 4; c++) begin
         write_ctl(c[1] ? 32'h0000_0800 : 32'h0);
         ots_pin = c[0]; #1;
         check(io_tri_en == (c[1] & c[0]), "R7", $sformatf("tristate combo %0d", c),
               io_tri_en, c[1] & c[0]);
      end
      ots_pin = 1'b0;

      // R8 scan grant truth table
      for (int c = 0; c < 8; c++) begin
         write_ctl({18'd0, c[1], c[0], 12'd0});
         cfg_lockout = c[2]; #1;
         check(scan_en == (c[0] & c[1] & ~c[2]), "R8", $sformatf("scan combo %0d", c),
               scan_en, c[0] & c[1] & ~c[2]);
      end
      cfg_lockout = 1'b0;

      // R4 no runt phases on any output across all transitions
      for (int i = 0; i < NCLK; i++) begin
         check(n_runt[i] == 0, "R4", $sformatf("clk%0d runt phases", i), n_runt[i], 0);
      end

      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
   end

endmodule